// File: doc/BRIEF.md
# Multiplierless Two-Digit Signed-Digit FIR Core

This core is a pipelined finite-impulse-response filter in which every coefficient is a fixed constant made of at most two nonzero signed power-of-two digits. No multiplier is built. Each digit contributes one shifted copy of the sign-extended input sample, and the copy is bitwise inverted when the digit is negative. The +1 that two's-complement negation would need in each of those rows is not added per row. It is folded into a single constant row, equal to the number of negative digits in the coefficient set.

All rows are reduced in carry-save form by 4:2 compressors, each built from two 3:2 counters. No carry-propagating adder appears inside the core. Its result is a pair of 24-bit vectors, sum and carry, whose modulo-2^24 total is the filter output. A separate downstream adder completes the result. A tap whose coefficient is zero is flagged off, and its rows become constant zeros that synthesis removes.

The core is sample-driven. A sample is taken only when `in_valid` is high. Three cycles later, `out_valid` pulses for one cycle alongside the matching vector pair. The tap count, the coefficient width and each tap's digit positions and signs are parameters. The defaults give eight symmetric taps with the coefficients 0, 3, -6, 14, 14, -6, 3, 0 (tap 0 weighs the newest sample).

Top module: `csd_fir_core`

## Requirements
- R1: When `out_valid` is high, (`out_sum` + `out_carry`) mod 2^24 equals the sum over k of c[k] * x[n-k]. Here x[n] is the most recently accepted sample, x[n-k] is the sample accepted k samples earlier, and samples that precede reset count as zero.
- R2: A sample presented with `in_valid` high in cycle t produces `out_valid` high in cycle t+3 only. One output pulse appears per accepted sample, and samples on consecutive cycles give outputs on consecutive cycles.
- R3: While `in_valid` is low, `in_sample` is ignored: the tap history does not move, and the next result depends only on accepted samples.
- R4: A synchronous reset clears the tap history and all pipeline registers. In the first cycle after reset, `out_valid`, `out_sum` and `out_carry` are all zero, and samples presented during reset are not taken.
- R5: With the default parameters, the coefficients for taps 0 to 7 are 0, 3, -6, 14, 14, -6, 3, 0. A single sample of 1 followed by zeros therefore produces exactly that output sequence.
- R6: Input samples are two's-complement values of `SAMPLE_W` bits, sign-extended before shifting. Full-scale values -128 and 127 give correct results under R1.
- R7: `out_sum` and `out_carry` keep their value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted on the rising edge while high |
| in_sample | input | SAMPLE_W (8) | Two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result pair |
| out_sum | output | 24 | Carry-save sum vector |
| out_carry | output | 24 | Carry-save carry vector |

## Verification
The properties assume that `in_valid` and `rst` are always 0 or 1, never unknown. They also assume that reset lasts at least one full clock cycle, because the latency checks look back three cycles and rely on the valid pipeline having been cleared. The stimulus changes every input at the falling edge only and holds reset for several cycles. Between samples it leaves `in_sample` at unrelated values with the strobe low, so the ignore and hold properties are exercised on realistic, changing data rather than on a quiet bus.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;

    // Width of the carry-save result vectors handed to the final adder.
    localparam int unsigned ACC_W = 24;

    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t s;
        acc_t c;
    } cs_pair_t;

    // One 3:2 counter row: three addends in, a sum and a shifted carry out.
    function automatic cs_pair_t csa32(input acc_t a, input acc_t b, input acc_t c);
        cs_pair_t r;
        r.s = a ^ b ^ c;
        r.c = ((a & b) | (a & c) | (b & c)) << 1;
        return r;
    endfunction

    // 4:2 compressor built from two chained 3:2 counters.
    function automatic cs_pair_t compress42(input acc_t a, input acc_t b,
                                            input acc_t c, input acc_t d);
        cs_pair_t t;
        t = csa32(a, b, c);
        return csa32(t.s, t.c, d);
    endfunction

endpackage

// File: rtl/csd_fir_delay_line.sv
module csd_fir_delay_line #(
    parameter int NTAPS    = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [SAMPLE_W-1:0]                in_sample,
    output logic [NTAPS-1:0][SAMPLE_W-1:0]     taps,
    output logic                               taps_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps       <= '0;
            taps_valid <= 1'b0;
        end else begin
            taps_valid <= in_valid;
            if (in_valid) begin
                taps[0] <= in_sample;
                for (int k = 1; k < NTAPS; k++) begin
                    taps[k] <= taps[k-1];
                end
            end
        end
    end

    AST_DL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taps)); // R3

endmodule

// File: rtl/csd_fir_rows.sv
module csd_fir_rows #(
    parameter int NTAPS    = 8,
    parameter int SAMPLE_W = 8,
    parameter int POS_W    = 3,
    parameter logic [NTAPS*POS_W-1:0] HI_POS = '0,
    parameter logic [NTAPS*POS_W-1:0] LO_POS = '0,
    parameter logic [NTAPS-1:0]       HI_NEG = '0,
    parameter logic [NTAPS-1:0]       LO_NEG = '0,
    parameter logic [NTAPS-1:0]       TAP_ON = '0,
    localparam int NROWS = 2 * NTAPS + 1
) (
    input  logic [NTAPS-1:0][SAMPLE_W-1:0]            taps,
    output logic [NROWS-1:0][csd_fir_pkg::ACC_W-1:0]  rows
);
    import csd_fir_pkg::*;

    // Number of inverted rows; each needs a +1 that is gathered here.
    function automatic int count_neg();
        int n;
        n = 0;
        for (int k = 0; k < NTAPS; k++) begin
            if (TAP_ON[k]) begin
                n += int'(HI_NEG[k]) + int'(LO_NEG[k]);
            end
        end
        return n;
    endfunction

    localparam int NEG_CNT = count_neg();

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        if (TAP_ON[k]) begin : g_live
            acc_t xe, hi_sh, lo_sh;
            assign xe    = {{(ACC_W-SAMPLE_W){taps[k][SAMPLE_W-1]}}, taps[k]};
            assign hi_sh = xe << HI_POS[k*POS_W +: POS_W];
            assign lo_sh = xe << LO_POS[k*POS_W +: POS_W];
            assign rows[2*k]   = HI_NEG[k] ? ~hi_sh : hi_sh;
            assign rows[2*k+1] = LO_NEG[k] ? ~lo_sh : lo_sh;
        end else begin : g_dead
            assign rows[2*k]   = '0;
            assign rows[2*k+1] = '0;
        end
    end

    assign rows[NROWS-1] = acc_t'(NEG_CNT);

endmodule

// File: rtl/csd_fir_group_stage.sv
module csd_fir_group_stage #(
    parameter int NROWS = 17,
    localparam int NGRP = (NROWS + 3) / 4,
    localparam int NPAD = NGRP * 4
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      in_valid,
    input  logic [NROWS-1:0][csd_fir_pkg::ACC_W-1:0]  rows,
    output logic [NGRP-1:0][csd_fir_pkg::ACC_W-1:0]   grp_s,
    output logic [NGRP-1:0][csd_fir_pkg::ACC_W-1:0]   grp_c,
    output logic                                      grp_valid
);
    import csd_fir_pkg::*;

    logic [NPAD-1:0][ACC_W-1:0] pad;

    always_comb begin
        pad = '0;
        for (int r = 0; r < NROWS; r++) begin
            pad[r] = rows[r];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cs_pair_t cmp;
        acc_t     s_q, c_q;

        always_comb begin
            cmp = compress42(pad[4*g], pad[4*g+1], pad[4*g+2], pad[4*g+3]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
                c_q <= '0;
            end else if (in_valid) begin
                s_q <= cmp.s;
                c_q <= cmp.c;
            end
        end

        assign grp_s[g] = s_q;
        assign grp_c[g] = c_q;

        AST_GROUP_CONSERVE: assert property (@(posedge clk) disable iff (rst)
            acc_t'(cmp.s + cmp.c) ==
            acc_t'(pad[4*g] + pad[4*g+1] + pad[4*g+2] + pad[4*g+3])); // R1
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_valid <= 1'b0;
        end else begin
            grp_valid <= in_valid;
        end
    end

endmodule

// File: rtl/csd_fir_merge_stage.sv
module csd_fir_merge_stage #(
    parameter int NGRP = 5
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     in_valid,
    input  logic [NGRP-1:0][csd_fir_pkg::ACC_W-1:0]  grp_s,
    input  logic [NGRP-1:0][csd_fir_pkg::ACC_W-1:0]  grp_c,
    output logic                                     out_valid,
    output logic [csd_fir_pkg::ACC_W-1:0]            out_sum,
    output logic [csd_fir_pkg::ACC_W-1:0]            out_carry
);
    import csd_fir_pkg::*;

    cs_pair_t acc;
    acc_t     grp_total;   // reference total, used only by the check below

    always_comb begin
        acc.s     = grp_s[0];
        acc.c     = grp_c[0];
        grp_total = grp_s[0] + grp_c[0];
        for (int g = 1; g < NGRP; g++) begin
            acc       = compress42(acc.s, acc.c, grp_s[g], grp_c[g]);
            grp_total = grp_total + grp_s[g] + grp_c[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_carry <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sum   <= acc.s;
                out_carry <= acc.c;
            end
        end
    end

    AST_MERGE_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> acc_t'(out_sum + out_carry) == $past(grp_total)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_sum) && $stable(out_carry))); // R7

endmodule

// File: rtl/csd_fir_core.sv
module csd_fir_core #(
    parameter int NTAPS    = 8,
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 6,
    localparam int POS_W   = $clog2(COEF_W),
    // Digit positions and signs per tap; tap k sits at slice k. Defaults give
    // 0, 3(=4-1), -6(=-8+2), 14(=16-2), 14, -6, 3, 0.
    parameter logic [NTAPS*POS_W-1:0] HI_POS =
        {3'd0, 3'd2, 3'd3, 3'd4, 3'd4, 3'd3, 3'd2, 3'd0},
    parameter logic [NTAPS*POS_W-1:0] LO_POS =
        {3'd0, 3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0},
    parameter logic [NTAPS-1:0] HI_NEG = 8'b0010_0100,
    parameter logic [NTAPS-1:0] LO_NEG = 8'b0101_1010,
    parameter logic [NTAPS-1:0] TAP_ON = 8'b0111_1110
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [SAMPLE_W-1:0]             in_sample,
    output logic                            out_valid,
    output logic [csd_fir_pkg::ACC_W-1:0]   out_sum,
    output logic [csd_fir_pkg::ACC_W-1:0]   out_carry
);
    import csd_fir_pkg::*;

    localparam int NROWS = 2 * NTAPS + 1;
    localparam int NGRP  = (NROWS + 3) / 4;

    logic [NTAPS-1:0][SAMPLE_W-1:0] taps;
    logic                           taps_valid;
    logic [NROWS-1:0][ACC_W-1:0]    rows;
    logic [NGRP-1:0][ACC_W-1:0]     grp_s, grp_c;
    logic                           grp_valid;

    csd_fir_delay_line #(
        .NTAPS    (NTAPS),
        .SAMPLE_W (SAMPLE_W)
    ) u_dline (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .taps       (taps),
        .taps_valid (taps_valid)
    );

    csd_fir_rows #(
        .NTAPS    (NTAPS),
        .SAMPLE_W (SAMPLE_W),
        .POS_W    (POS_W),
        .HI_POS   (HI_POS),
        .LO_POS   (LO_POS),
        .HI_NEG   (HI_NEG),
        .LO_NEG   (LO_NEG),
        .TAP_ON   (TAP_ON)
    ) u_rows (
        .taps (taps),
        .rows (rows)
    );

    csd_fir_group_stage #(
        .NROWS (NROWS)
    ) u_group (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (taps_valid),
        .rows      (rows),
        .grp_s     (grp_s),
        .grp_c     (grp_c),
        .grp_valid (grp_valid)
    );

    csd_fir_merge_stage #(
        .NGRP (NGRP)
    ) u_merge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (grp_valid),
        .grp_s     (grp_s),
        .grp_c     (grp_c),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3)); // R2

    AST_VALID_ISSUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_sum == '0 && out_carry == '0)); // R4

endmodule

// File: tb/sim_csd_fir_core.sv
`timescale 1ns/1ps
module sim_csd_fir_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = 8'h00;
    logic        out_valid;
    logic [23:0] out_sum, out_carry;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    int coef [8] = '{0, 3, -6, 14, 14, -6, 3, 0};
    int hist [8];

    always #4 clk = ~clk;   // 125 MHz

    csd_fir_core u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry)
    );

    function automatic int model_y();
        int y = 0;
        for (int k = 0; k < 8; k++) y += coef[k] * hist[k];
        return y;
    endfunction

    function automatic void model_push(input int x);
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < 8; k++) hist[k] = 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int total();
        logic [23:0] t;
        t = out_sum + out_carry;
        return int'(t);
    endfunction

    // Push one sample, then check the strobe and the result three cycles on.
    task automatic push_check(input int x, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'(x);
        model_push(x);
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = 8'h5A;
        @(negedge clk);
        chk("R2 strobe low before result", int'(out_valid), 0);
        @(negedge clk);
        chk("R2 strobe high at +3", int'(out_valid), 1);
        chk(req, total(), model_y() & 24'hFFFFFF);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;          // must not be taken while in reset
        in_sample = 8'd77;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        model_clear();
        chk("R4 out_valid after reset", int'(out_valid), 0);
        chk("R4 out_sum after reset", int'(out_sum), 0);
        chk("R4 out_carry after reset", int'(out_carry), 0);
    endtask

    task automatic t_impulse();
        int exp_list [8] = '{0, 3, -6, 14, 14, -6, 3, 0};
        push_check(1, "R5 impulse tap 0");
        for (int k = 1; k < 8; k++) begin
            push_check(0, "R5 impulse response");
            chk("R5 coefficient", model_y(), exp_list[k]);
        end
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 12; i++) push_check(i * 7 - 30, "R1 ramp");
    endtask

    task automatic t_extremes();
        for (int i = 0; i < 10; i++) push_check((i % 2 == 0) ? 127 : -128, "R6 full scale");
        for (int i = 0; i < 8; i++) push_check(-128, "R6 negative full scale");
    endtask

    task automatic t_gap();
        int s0, c0;
        push_check(42, "R1 before gap");
        s0 = int'(out_sum);
        c0 = int'(out_carry);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 8'(i * 37 + 11);
            chk("R7 out_sum held", int'(out_sum), s0);
            chk("R7 out_carry held", int'(out_carry), c0);
            chk("R2 no strobe when idle", int'(out_valid), 0);
        end
        push_check(-9, "R3 idle samples ignored");
    endtask

    task automatic t_burst();
        int xs  [6] = '{5, -3, 100, -77, 12, 1};
        int exp [6];
        for (int i = 0; i < 6; i++) begin
            model_push(xs[i]);
            exp[i] = model_y() & 24'hFFFFFF;
        end
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R2 back-to-back strobe", int'(out_valid), 1);
                chk("R1 back-to-back result", total(), exp[i-3]);
            end
            if (i < 6) begin
                in_valid  = 1'b1;
                in_sample = 8'(xs[i]);
            end else begin
                in_valid  = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 strobe ends after burst", int'(out_valid), 0);
    endtask

    task automatic t_midreset();
        push_check(90, "R1 pre-reset");
        push_check(-60, "R1 pre-reset");
        do_reset();
        push_check(1, "R4 history cleared tap 0");
        push_check(0, "R4 history cleared tap 1");
        push_check(0, "R4 history cleared tap 2");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        t_impulse();
        t_ramp();
        t_extremes();
        t_gap();
        t_burst();
        t_midreset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule